// File: doc/BRIEF.md
# Latency-Insensitive Dataflow Node Wrapper

This block turns a small synchronous state machine into a node that can sit in a latency-insensitive dataflow network. Two producer streams (`a` and `b`) arrive through valid/ready handshakes into small queues inside the block. Two result streams (`c` and `d`) leave through valid/ready handshakes from small output queues, also inside the block. One step of the wrapped machine is a model cycle. It consumes one item from each input stream and produces one item on each output stream, however many real clocks that step takes.

The wrapped machine holds an 8-bit state `s` that starts at zero. Output `c` carries `a + b + s` (modulo 256) and needs both inputs. Output `d` is a copy of `b` and needs only `b`. Each output has its own completion flag. It fires as soon as the inputs it depends on are at the head of their queues and its own queue has room. It does not wait for unrelated inputs or for the other output, so the wrapper adds no false dependency.

A separate finish step runs once both flags are set. It removes the head of each input queue, clears both flags and loads the next state `s ^ a ^ b` through an enable. Between finish steps the state holds for any number of clocks.

Top module: `dfw_node`

## Requirements
- R1: The n-th item on `c_data` equals (a_n + b_n + s_n) mod 256. Here a_n and b_n are the n-th accepted items on `a` and `b`, s_0 = 0 and s_(n+1) = s_n XOR a_n XOR b_n.
- R2: The n-th item on `d_data` equals b_n.
- R3: The `d` item of a model cycle is presented on `d_valid`/`d_data` while no `a` item for that cycle has arrived.
- R4: No `c` item for a model cycle is presented until both its `a` and `b` items have arrived.
- R5: Each output emits exactly one item per model cycle. After all inputs are consumed, no further items appear on either output.
- R6: A model cycle's inputs are consumed only after both of its outputs have fired. A second `b` item does not produce a second `d` item until the first cycle's `c` item has fired.
- R7: Output values do not depend on input arrival timing or on output back-pressure. Random stalls give the same streams as the reference.
- R8: During and right after reset, `c_valid` and `d_valid` are 0, `a_ready` and `b_ready` are 1, and the state is 0.
- R9: `a_ready` stays 1 while the `a` queue holds fewer than IN_DEPTH items and drops to 0 once it holds IN_DEPTH items that no finish step has consumed.
- R10: While an output is valid and not ready, it stays valid with unchanged data on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_valid | input | 1 | Producer `a` offers an item |
| a_ready | output | 1 | The `a` queue has room |
| a_data | input | 8 | Item on stream `a` |
| b_valid | input | 1 | Producer `b` offers an item |
| b_ready | output | 1 | The `b` queue has room |
| b_data | input | 8 | Item on stream `b` |
| c_valid | output | 1 | Result `c` available |
| c_ready | input | 1 | Consumer takes `c` |
| c_data | output | 8 | Result a + b + s |
| d_valid | output | 1 | Result `d` available |
| d_ready | input | 1 | Consumer takes `d` |
| d_data | output | 8 | Result copy of b |

## Verification
On every clock, the assertions watch the firing and flag protocol. Each output fires at most once before a finish step, a fire sets its flag, a finish clears both flags with inputs still present, and the state stays unchanged outside finish steps. They also watch that a stalled output holds its data. The value streams need the bench's scenarios, which compare them against an independent reference of the state machine under random stalls and back-pressure. The same applies to the decoupling of `d` from a missing `a`, to the blocking of a second `d` item and to queue-full behaviour.

// File: rtl/dfw_pkg.sv
package dfw_pkg;
  localparam int unsigned DW = 8;
  typedef logic [DW-1:0] word_t;

  // Result of the c output for one model cycle
  function automatic word_t c_value(word_t a, word_t b, word_t s);
    return a + b + s;
  endfunction

  // Next state after a model cycle
  function automatic word_t s_next(word_t a, word_t b, word_t s);
    return s ^ a ^ b;
  endfunction
endpackage

// File: rtl/dfw_fifo.sv
module dfw_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4   // power of two, at least 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         nonempty
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam logic [AW:0] CNT_MAX = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;

  assign full     = (count == CNT_MAX);
  assign nonempty = (count != '0);
  assign head     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= push_data;
        wr_ptr      <= wr_ptr + 1'b1;
      end
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      count <= count + {{AW{1'b0}}, push} - {{AW{1'b0}}, pop};
    end
  end
endmodule

// File: rtl/dfw_core.sv
module dfw_core
  import dfw_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t a_head,
  input  logic  a_ne,
  input  word_t b_head,
  input  logic  b_ne,
  input  logic  c_full,
  input  logic  d_full,
  output logic  fire_c,
  output word_t c_word,
  output logic  fire_d,
  output word_t d_word,
  output logic  finish,
  output logic  done_c,
  output logic  done_d,
  output word_t s_q
);
  // Each output watches only its own dependency set
  assign fire_c = a_ne && b_ne && !c_full && !done_c;
  assign fire_d = b_ne && !d_full && !done_d;
  assign finish = done_c && done_d;

  assign c_word = c_value(a_head, b_head, s_q);
  assign d_word = b_head;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_c <= 1'b0;
      done_d <= 1'b0;
    end else if (finish) begin
      done_c <= 1'b0;
      done_d <= 1'b0;
    end else begin
      if (fire_c) done_c <= 1'b1;
      if (fire_d) done_d <= 1'b1;
    end
  end

  // State loads only on the finish enable
  always_ff @(posedge clk) begin
    if (!rst_n)      s_q <= '0;
    else if (finish) s_q <= s_next(a_head, b_head, s_q);
  end
endmodule

// File: rtl/dfw_node.sv
module dfw_node #(
  parameter int unsigned IN_DEPTH  = 4,
  parameter int unsigned OUT_DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   a_valid,
  output logic                   a_ready,
  input  logic [dfw_pkg::DW-1:0] a_data,
  input  logic                   b_valid,
  output logic                   b_ready,
  input  logic [dfw_pkg::DW-1:0] b_data,
  output logic                   c_valid,
  input  logic                   c_ready,
  output logic [dfw_pkg::DW-1:0] c_data,
  output logic                   d_valid,
  input  logic                   d_ready,
  output logic [dfw_pkg::DW-1:0] d_data
);
  import dfw_pkg::*;
  localparam int unsigned N_IN  = 2;
  localparam int unsigned N_OUT = 2;

  logic [N_IN-1:0]  in_vld, in_full, in_ne;
  word_t            in_dat  [N_IN];
  word_t            in_head [N_IN];
  logic [N_OUT-1:0] out_push, out_full, out_vld, out_rdy;
  word_t            out_word [N_OUT];
  word_t            out_head [N_OUT];

  // Named internal events for the checker
  logic  fire_c, fire_d, finish, done_c, done_d, a_ne, b_ne;
  word_t s_q, c_word, d_word;

  assign in_vld    = {b_valid, a_valid};
  assign in_dat[0] = a_data;
  assign in_dat[1] = b_data;
  assign a_ready   = !in_full[0];
  assign b_ready   = !in_full[1];
  assign a_ne      = in_ne[0];
  assign b_ne      = in_ne[1];

  for (genvar k = 0; k < N_IN; k++) begin : g_in
    dfw_fifo #(.W(DW), .DEPTH(IN_DEPTH)) u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (in_vld[k] && !in_full[k]),
      .push_data (in_dat[k]),
      .full      (in_full[k]),
      .pop       (finish),
      .head      (in_head[k]),
      .nonempty  (in_ne[k])
    );
  end

  dfw_core u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_head (in_head[0]),
    .a_ne   (a_ne),
    .b_head (in_head[1]),
    .b_ne   (b_ne),
    .c_full (out_full[0]),
    .d_full (out_full[1]),
    .fire_c (fire_c),
    .c_word (c_word),
    .fire_d (fire_d),
    .d_word (d_word),
    .finish (finish),
    .done_c (done_c),
    .done_d (done_d),
    .s_q    (s_q)
  );

  assign out_push    = {fire_d, fire_c};
  assign out_word[0] = c_word;
  assign out_word[1] = d_word;
  assign out_rdy     = {d_ready, c_ready};

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    dfw_fifo #(.W(DW), .DEPTH(OUT_DEPTH)) u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (out_push[k]),
      .push_data (out_word[k]),
      .full      (out_full[k]),
      .pop       (out_vld[k] && out_rdy[k]),
      .head      (out_head[k]),
      .nonempty  (out_vld[k])
    );
  end

  assign c_valid = out_vld[0];
  assign c_data  = out_head[0];
  assign d_valid = out_vld[1];
  assign d_data  = out_head[1];
endmodule

// File: rtl/dfw_node_chk.sv
module dfw_node_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fire_c,
  input logic       fire_d,
  input logic       finish,
  input logic       done_c,
  input logic       done_d,
  input logic       a_ne,
  input logic       b_ne,
  input logic [7:0] s_q,
  input logic       c_valid,
  input logic       c_ready,
  input logic [7:0] c_data,
  input logic       d_valid,
  input logic       d_ready,
  input logic [7:0] d_data
);
  // R5
  c_fires_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_c |=> (done_c && !fire_c));
  // R5
  d_fires_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_d |=> (done_d && !fire_d));
  // R4
  c_needs_inputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_c |-> (a_ne && b_ne));
  // R6
  finish_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (!done_c && !done_d));
  // R6
  finish_inputs_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> (a_ne && b_ne));
  // R7
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> $stable(s_q));
  // R10
  c_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_valid && !c_ready) |=> (c_valid && $stable(c_data)));
  // R10
  d_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && !d_ready) |=> (d_valid && $stable(d_data)));
endmodule

bind dfw_node dfw_node_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .fire_c  (fire_c),
  .fire_d  (fire_d),
  .finish  (finish),
  .done_c  (done_c),
  .done_d  (done_d),
  .a_ne    (a_ne),
  .b_ne    (b_ne),
  .s_q     (s_q),
  .c_valid (c_valid),
  .c_ready (c_ready),
  .c_data  (c_data),
  .d_valid (d_valid),
  .d_ready (d_ready),
  .d_data  (d_data)
);

// File: tb/dfw_node_tb.sv
module dfw_node_tb;
  localparam int NV = 16;
  localparam int IN_DEPTH = 4;
  // Stimulus: a in the high byte, b in the low byte
  localparam logic [15:0] VEC [NV] = '{
    16'h0000, 16'h0102, 16'hFF01, 16'h8080, 16'h3C5A, 16'hA5C3, 16'h7F7F, 16'h10EF,
    16'hFE02, 16'h0908, 16'h5555, 16'hAAAA, 16'h00FF, 16'hFF00, 16'h1234, 16'hCDEF};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_valid = 1'b0, b_valid = 1'b0, c_ready = 1'b0, d_ready = 1'b0;
  logic [7:0] a_data = '0, b_data = '0;
  logic a_ready, b_ready, c_valid, d_valid;
  logic [7:0] c_data, d_data;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [7:0] got_c [NV];
  logic [7:0] got_d [NV];

  always #10 clk = ~clk;

  dfw_node #(.IN_DEPTH(IN_DEPTH), .OUT_DEPTH(4)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
    .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data),
    .c_valid(c_valid), .c_ready(c_ready), .c_data(c_data),
    .d_valid(d_valid), .d_ready(d_ready), .d_data(d_data));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; a_valid = 0; b_valid = 0; c_ready = 0; d_ready = 0;
    repeat (3) @(negedge clk);
    check(!c_valid && !d_valid, "R8 valids in reset", {c_valid, d_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push_a(input logic [7:0] v);
    a_valid = 1; a_data = v;
    while (!a_ready) @(negedge clk);
    @(negedge clk);
    a_valid = 0;
  endtask

  task automatic push_b(input logic [7:0] v);
    b_valid = 1; b_data = v;
    while (!b_ready) @(negedge clk);
    @(negedge clk);
    b_valid = 0;
  endtask

  task automatic pop_c();
    c_ready = 1; @(negedge clk); c_ready = 0;
  endtask

  task automatic pop_d();
    d_ready = 1; @(negedge clk); d_ready = 0;
  endtask

  task automatic prod_a();
    int idx = 0;
    while (idx < NV) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) a_valid = 0;
      else begin
        a_valid = 1; a_data = VEC[idx][15:8];
        if (a_ready) idx++;
      end
    end
    @(negedge clk); a_valid = 0;
  endtask

  task automatic prod_b();
    int idx = 0;
    while (idx < NV) begin
      @(negedge clk);
      if ($urandom_range(0, 2) == 0) b_valid = 0;
      else begin
        b_valid = 1; b_data = VEC[idx][7:0];
        if (b_ready) idx++;
      end
    end
    @(negedge clk); b_valid = 0;
  endtask

  task automatic cons_c();
    int n = 0;
    bit held = 0;
    logic [7:0] last = '0;
    while (n < NV) begin
      @(negedge clk);
      if (held) check(c_valid && c_data == last, "R10 c held under back-pressure", c_data, last);
      c_ready = ($urandom_range(0, 2) != 0);
      held = c_valid && !c_ready;
      last = c_data;
      if (c_valid && c_ready) begin got_c[n] = c_data; n++; end
    end
    @(negedge clk); c_ready = 0;
  endtask

  task automatic cons_d();
    int n = 0;
    bit held = 0;
    logic [7:0] last = '0;
    while (n < NV) begin
      @(negedge clk);
      if (held) check(d_valid && d_data == last, "R10 d held under back-pressure", d_data, last);
      d_ready = ($urandom_range(0, 1) != 0);
      held = d_valid && !d_ready;
      last = d_data;
      if (d_valid && d_ready) begin got_d[n] = d_data; n++; end
    end
    @(negedge clk); d_ready = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] st;
    // Reset state
    do_reset();
    check(!c_valid && !d_valid, "R8 outputs idle after reset", {c_valid, d_valid}, 0);
    check(a_ready && b_ready, "R8 inputs ready after reset", {a_ready, b_ready}, 3);

    // d fires without a, c waits for a
    push_b(8'h11);
    repeat (5) @(negedge clk);
    check(d_valid && d_data == 8'h11, "R3 d present without a", d_data, 8'h11);
    check(!c_valid, "R4 c absent without a", c_valid, 0);
    push_b(8'h22);
    repeat (2) @(negedge clk);
    pop_d();
    repeat (4) @(negedge clk);
    check(!d_valid, "R6 no second d before c fires", d_valid, 0);
    push_a(8'h05);
    repeat (5) @(negedge clk);
    check(c_valid && c_data == 8'h16, "R1 first c with zero state", c_data, 8'h16);
    pop_c();
    check(d_valid && d_data == 8'h22, "R2 second d after finish", d_data, 8'h22);
    pop_d();
    push_a(8'h03);
    repeat (5) @(negedge clk);
    // state is 05^11 = 14, so 03+22+14 = 39
    check(c_valid && c_data == 8'h39, "R1 c uses updated state", c_data, 8'h39);
    pop_c();

    // Input queue fills without b
    do_reset();
    for (int i = 0; i < IN_DEPTH - 1; i++) push_a(8'(i));
    check(a_ready, "R9 a_ready with room left", a_ready, 1);
    push_a(8'hEE);
    check(!a_ready, "R9 a_ready low when full", a_ready, 0);
    check(!c_valid && !d_valid, "R4 nothing fires with a only", {c_valid, d_valid}, 0);

    // Random streaming against reference
    do_reset();
    fork
      prod_a();
      prod_b();
      cons_c();
      cons_d();
    join
    st = 8'h00;
    for (int i = 0; i < NV; i++) begin
      logic [7:0] av, bv, ec;
      av = VEC[i][15:8];
      bv = VEC[i][7:0];
      ec = 8'((int'(av) + int'(bv) + int'(st)) % 256);
      check(got_c[i] == ec, "R1 R7 c stream", got_c[i], ec);
      check(got_d[i] == bv, "R2 d stream", got_d[i], bv);
      st = (st ^ bv) ^ av;
    end
    repeat (20) @(negedge clk);
    check(!c_valid && !d_valid, "R5 no extra outputs", {c_valid, d_valid}, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule